// File: doc/BRIEF.md
# Fixed-Point Rounding and Clipping Unit

This unit narrows a fixed-point word of `IN_W` bits by discarding its `DROP_W` lowest fraction bits and presents five results side by side: the truncated value, a nearest rounding that breaks ties away from zero (signed data) or upward (unsigned data), and a nearest rounding that breaks ties towards an even result. Each of the two rounded results is available twice. One form simply wraps when rounding carries past the top of the output range. The other form is held at the largest representable output instead.

The choice between signed and unsigned data is a build-time parameter. Optional register stages before and after the arithmetic are set by two separate depth parameters. A valid flag moves through the same stages as the data. A datapath uses the unit wherever a wide accumulator or product has to be requantised to a narrower word. It keeps whichever of the five outputs suits the downstream precision budget, and synthesis trims away the rest.

Top module: `fxr_round_unit`

## Requirements
- R1: The truncated output is the input shifted right arithmetically by `DROP_W` bits, which is floor division by 2^`DROP_W`. For signed data with IN_W=4 and DROP_W=1, input -1 gives -1 and input 7 gives 3.
- R2: For signed data, the half-away outputs round an exact tie away from zero. With IN_W=4 and DROP_W=1, input 1 (0.5) gives 1 and input -1 (-0.5) gives -1.
- R3: For unsigned data, the half-away outputs round an exact tie upward. With IN_W=5 and DROP_W=2, input 2 (0.5) gives 1.
- R4: The half-even outputs round an exact tie to the even neighbour. With IN_W=4 and DROP_W=1 and signed data, inputs 1, 3, -1 and -3 give 0, 2, 0 and -2. With IN_W=5 and DROP_W=2, input 10 (2.5) gives 2.
- R5: When the discarded part is not an exact tie, both rounded modes give the nearest output value. A discarded part above one half rounds up, and one below one half rounds down.
- R6: The wrapping forms keep only the low `IN_W-DROP_W` bits of a result that carries past the largest output. Signed input 7 at IN_W=4 and DROP_W=1 gives -4. Unsigned input 15 gives 0, and unsigned input 30 at IN_W=5 and DROP_W=2 gives 0.
- R7: The clipping forms replace such an overflowing result with the largest output value (2^(n-1)-1 signed, 2^n-1 unsigned, where n = IN_W-DROP_W). Signed input 7 gives 3 and unsigned input 15 gives 7 at IN_W=4 and DROP_W=1. No other result is changed.
- R8: When `DROP_W` is zero or negative, every output equals the input unchanged, and the output width equals `IN_W`.
- R9: `valid_o` and the five results follow `valid_i` and `din` after exactly `PIPE_IN + PIPE_OUT` clock edges. A depth of zero on a side makes that side combinational.
- R10: A synchronous active-high `rst` clears every pipeline register, so that `valid_o` and all five outputs read zero on the cycle after reset while the inputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Input word qualifier |
| din | input | IN_W | Input fixed-point word |
| valid_o | output | 1 | Output word qualifier |
| trunc_o | output | OUT_W | Truncated (floor) result |
| away_wrap_o | output | OUT_W | Half-away/half-up result, wrapping |
| away_clip_o | output | OUT_W | Half-away/half-up result, clipped at maximum |
| even_wrap_o | output | OUT_W | Half-even result, wrapping |
| even_clip_o | output | OUT_W | Half-even result, clipped at maximum |

## Verification
The bench builds five copies side by side. Signed and unsigned copies use IN_W=4/DROP_W=1 and IN_W=5/DROP_W=2, and one signed copy uses DROP_W=0. Their pipeline splits are 1+1, 0+1, 2+0, 1+2 and 0+0. These small widths let every input code be swept twice, with valid bubbles, so every tie, every overflowing round-up, the most negative input and the pass-through case are all reached. Mixing the pipeline depths exercises latency and the combinational paths on each side. A reset issued mid-stream shows that the registers clear.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

    // Facts about the discarded fraction needed to decide a round-up.
    typedef struct packed {
        logic half_bit;   // most significant discarded bit
        logic tail_nz;    // any discarded bit below half_bit is set
        logic neg;        // input is negative (signed data only)
        logic keep_lsb;   // least significant retained bit
    } fxr_frac_t;

    // Position of each result inside the packed result bundle.
    typedef enum int {
        FXR_TRUNC     = 0,
        FXR_AWAY_WRAP = 1,
        FXR_AWAY_CLIP = 2,
        FXR_EVEN_WRAP = 3,
        FXR_EVEN_CLIP = 4
    } fxr_sel_e;

    localparam int FXR_NUM_RES = 5;

    // Output width for a given input width and discarded-bit count.
    function automatic int fxr_out_w(input int in_w, input int drop_w);
        return (drop_w > 0) ? (in_w - drop_w) : in_w;
    endfunction

    // Nearest rounding, ties away from zero (ties up when neg is never set).
    function automatic logic fxr_inc_away(input fxr_frac_t f);
        return f.half_bit & (f.tail_nz | ~f.neg);
    endfunction

    // Nearest rounding, ties to the even retained value.
    function automatic logic fxr_inc_even(input fxr_frac_t f);
        return f.half_bit & (f.tail_nz | f.keep_lsb);
    endfunction

endpackage

// File: rtl/fxr_pipe.sv
module fxr_pipe #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vld_i,
    input  logic [WIDTH-1:0] dat_i,
    output logic             vld_o,
    output logic [WIDTH-1:0] dat_o
);

    generate
        if (DEPTH <= 0) begin : g_wire
            assign vld_o = vld_i;
            assign dat_o = dat_i;
        end else begin : g_regs
            logic             vld_q [DEPTH];
            logic [WIDTH-1:0] dat_q [DEPTH];

            for (genvar s = 0; s < DEPTH; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        vld_q[s] <= 1'b0;
                        dat_q[s] <= '0;
                    end else if (s == 0) begin
                        vld_q[s] <= vld_i;
                        dat_q[s] <= dat_i;
                    end else begin
                        vld_q[s] <= vld_q[s-1];
                        dat_q[s] <= dat_q[s-1];
                    end
                end
            end

            assign vld_o = vld_q[DEPTH-1];
            assign dat_o = dat_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/fxr_frac_decode.sv
module fxr_frac_decode
    import fxr_pkg::*;
#(
    parameter int IN_W      = 4,
    parameter int DROP_W    = 1,
    parameter bit IS_SIGNED = 1'b1,
    localparam int OUT_W    = IN_W - DROP_W
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] keep,
    output fxr_frac_t        frac
);

    logic tail_nz;

    generate
        if (DROP_W > 1) begin : g_tail
            assign tail_nz = |din[DROP_W-2:0];
        end else begin : g_no_tail
            assign tail_nz = 1'b0;
        end
    endgenerate

    // Dropping the low bits of a two's complement word is a floor shift.
    assign keep = din[IN_W-1:DROP_W];

    always_comb begin
        frac.half_bit = din[DROP_W-1];
        frac.tail_nz  = tail_nz;
        frac.neg      = IS_SIGNED ? din[IN_W-1] : 1'b0;
        frac.keep_lsb = din[DROP_W];
    end

endmodule

// File: rtl/fxr_inc_apply.sv
module fxr_inc_apply #(
    parameter int OUT_W     = 3,
    parameter bit IS_SIGNED = 1'b1,
    parameter bit CLIP      = 1'b0
) (
    input  logic [OUT_W-1:0] keep,
    input  logic             inc,
    output logic [OUT_W-1:0] res
);

    localparam logic [OUT_W-1:0] ALL_ONES = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] MAXV     = IS_SIGNED ? (ALL_ONES >> 1) : ALL_ONES;

    logic [OUT_W-1:0] sum;
    logic             ovf;

    assign sum = keep + {{(OUT_W-1){1'b0}}, inc};
    // Only a round-up from the top code can leave the range.
    assign ovf = inc && (keep == MAXV);

    generate
        if (CLIP) begin : g_clip
            assign res = ovf ? MAXV : sum;
        end else begin : g_wrap
            assign res = sum;
        end
    endgenerate

endmodule

// File: rtl/fxr_round_unit.sv
module fxr_round_unit
    import fxr_pkg::*;
#(
    parameter int IN_W      = 4,
    parameter int DROP_W    = 1,
    parameter bit IS_SIGNED = 1'b1,
    parameter int PIPE_IN   = 1,
    parameter int PIPE_OUT  = 1,
    localparam int OUT_W    = fxr_out_w(IN_W, DROP_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [IN_W-1:0]  din,
    output logic             valid_o,
    output logic [OUT_W-1:0] trunc_o,
    output logic [OUT_W-1:0] away_wrap_o,
    output logic [OUT_W-1:0] away_clip_o,
    output logic [OUT_W-1:0] even_wrap_o,
    output logic [OUT_W-1:0] even_clip_o
);

    localparam int BUND_W = FXR_NUM_RES * OUT_W;

    logic             vld_mid;
    logic [IN_W-1:0]  din_mid;
    logic [BUND_W-1:0] bund_mid;
    logic [BUND_W-1:0] bund_out;

    fxr_pipe #(.DEPTH(PIPE_IN), .WIDTH(IN_W)) u_pipe_in (
        .clk   (clk),
        .rst   (rst),
        .vld_i (valid_i),
        .dat_i (din),
        .vld_o (vld_mid),
        .dat_o (din_mid)
    );

    generate
        if (DROP_W <= 0) begin : g_pass
            for (genvar m = 0; m < FXR_NUM_RES; m++) begin : g_copy
                assign bund_mid[m*OUT_W +: OUT_W] = din_mid;
            end
        end else begin : g_round
            logic [OUT_W-1:0] keep;
            fxr_frac_t        frac;
            logic             inc_away;
            logic             inc_even;

            fxr_frac_decode #(
                .IN_W      (IN_W),
                .DROP_W    (DROP_W),
                .IS_SIGNED (IS_SIGNED)
            ) u_decode (
                .din  (din_mid),
                .keep (keep),
                .frac (frac)
            );

            assign inc_away = fxr_inc_away(frac);
            assign inc_even = fxr_inc_even(frac);
            assign bund_mid[FXR_TRUNC*OUT_W +: OUT_W] = keep;

            // Modes 1..4: (away|even) x (wrap|clip)
            for (genvar m = 1; m < FXR_NUM_RES; m++) begin : g_mode
                localparam bit IS_EVEN = (m >= FXR_EVEN_WRAP);
                localparam bit DO_CLIP = (m == FXR_AWAY_CLIP) || (m == FXR_EVEN_CLIP);
                fxr_inc_apply #(
                    .OUT_W     (OUT_W),
                    .IS_SIGNED (IS_SIGNED),
                    .CLIP      (DO_CLIP)
                ) u_apply (
                    .keep (keep),
                    .inc  (IS_EVEN ? inc_even : inc_away),
                    .res  (bund_mid[m*OUT_W +: OUT_W])
                );
            end
        end
    endgenerate

    fxr_pipe #(.DEPTH(PIPE_OUT), .WIDTH(BUND_W)) u_pipe_out (
        .clk   (clk),
        .rst   (rst),
        .vld_i (vld_mid),
        .dat_i (bund_mid),
        .vld_o (valid_o),
        .dat_o (bund_out)
    );

    assign trunc_o     = bund_out[FXR_TRUNC*OUT_W     +: OUT_W];
    assign away_wrap_o = bund_out[FXR_AWAY_WRAP*OUT_W +: OUT_W];
    assign away_clip_o = bund_out[FXR_AWAY_CLIP*OUT_W +: OUT_W];
    assign even_wrap_o = bund_out[FXR_EVEN_WRAP*OUT_W +: OUT_W];
    assign even_clip_o = bund_out[FXR_EVEN_CLIP*OUT_W +: OUT_W];

endmodule

// File: rtl/fxr_round_checker.sv
module fxr_round_checker #(
    parameter int IN_W      = 4,
    parameter int DROP_W    = 1,
    parameter bit IS_SIGNED = 1'b1,
    parameter int PIPE_IN   = 1,
    parameter int PIPE_OUT  = 1,
    localparam int OUT_W    = (DROP_W > 0) ? (IN_W - DROP_W) : IN_W
) (
    input logic             clk,
    input logic             rst,
    input logic             valid_o,
    input logic [OUT_W-1:0] trunc_o,
    input logic [OUT_W-1:0] away_wrap_o,
    input logic [OUT_W-1:0] away_clip_o,
    input logic [OUT_W-1:0] even_wrap_o,
    input logic [OUT_W-1:0] even_clip_o
);

    localparam int LAT = PIPE_IN + PIPE_OUT;
    localparam logic [OUT_W-1:0] ONES = {OUT_W{1'b1}};
    localparam logic [OUT_W-1:0] MAXV = IS_SIGNED ? (ONES >> 1) : ONES;
    localparam logic [OUT_W-1:0] ONE  = {{(OUT_W-1){1'b0}}, 1'b1};

    // R5: a rounded result is the floor or one step above it
    assert_away_step_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (away_wrap_o == trunc_o || away_wrap_o == trunc_o + ONE));

    assert_even_step_R5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (even_wrap_o == trunc_o || even_wrap_o == trunc_o + ONE));

    // R4: when the two tie rules disagree, the even rule lands on an even code
    assert_even_parity_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && even_wrap_o != away_wrap_o) |-> (even_wrap_o[0] == 1'b0));

    // R7: clipping differs from wrapping only on an overflowing round-up
    assert_away_clip_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && away_clip_o != away_wrap_o) |->
            (away_clip_o == MAXV && away_wrap_o == MAXV + ONE));

    assert_even_clip_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_o && even_clip_o != even_wrap_o) |->
            (even_clip_o == MAXV && even_wrap_o == MAXV + ONE));

    generate
        if (LAT > 0) begin : g_rst_chk
            // R10: registered output is idle on the cycle after reset
            assert_reset_idle_R10: assert property (@(posedge clk)
                $past(rst) |-> (!valid_o && trunc_o == '0));
        end
    endgenerate

endmodule

bind fxr_round_unit fxr_round_checker #(
    .IN_W      (IN_W),
    .DROP_W    (DROP_W),
    .IS_SIGNED (IS_SIGNED),
    .PIPE_IN   (PIPE_IN),
    .PIPE_OUT  (PIPE_OUT)
) u_fxr_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_o     (valid_o),
    .trunc_o     (trunc_o),
    .away_wrap_o (away_wrap_o),
    .away_clip_o (away_clip_o),
    .even_wrap_o (even_wrap_o),
    .even_clip_o (even_clip_o)
);

// File: tb/test_fxr_round_unit.sv
module test_fxr_round_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vin = 1'b0;
    logic [4:0] stim = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int hist_x [0:3];
    bit hist_v [0:3];

    always #5 clk = ~clk;

    // A: signed 4->3, 1+1
    logic       a_v; logic [2:0] a_t, a_aw, a_ac, a_ew, a_ec;
    fxr_round_unit #(.IN_W(4), .DROP_W(1), .IS_SIGNED(1'b1), .PIPE_IN(1), .PIPE_OUT(1)) i_fxr_round_unit (
        .clk(clk), .rst(rst), .valid_i(vin), .din(stim[3:0]), .valid_o(a_v),
        .trunc_o(a_t), .away_wrap_o(a_aw), .away_clip_o(a_ac), .even_wrap_o(a_ew), .even_clip_o(a_ec));

    // B: unsigned 4->3, 0+1
    logic       b_v; logic [2:0] b_t, b_aw, b_ac, b_ew, b_ec;
    fxr_round_unit #(.IN_W(4), .DROP_W(1), .IS_SIGNED(1'b0), .PIPE_IN(0), .PIPE_OUT(1)) i_fxr_round_unit_b (
        .clk(clk), .rst(rst), .valid_i(vin), .din(stim[3:0]), .valid_o(b_v),
        .trunc_o(b_t), .away_wrap_o(b_aw), .away_clip_o(b_ac), .even_wrap_o(b_ew), .even_clip_o(b_ec));

    // C: signed 5->3, 2+0
    logic       c_v; logic [2:0] c_t, c_aw, c_ac, c_ew, c_ec;
    fxr_round_unit #(.IN_W(5), .DROP_W(2), .IS_SIGNED(1'b1), .PIPE_IN(2), .PIPE_OUT(0)) i_fxr_round_unit_c (
        .clk(clk), .rst(rst), .valid_i(vin), .din(stim), .valid_o(c_v),
        .trunc_o(c_t), .away_wrap_o(c_aw), .away_clip_o(c_ac), .even_wrap_o(c_ew), .even_clip_o(c_ec));

    // D: unsigned 5->3, 1+2
    logic       d_v; logic [2:0] d_t, d_aw, d_ac, d_ew, d_ec;
    fxr_round_unit #(.IN_W(5), .DROP_W(2), .IS_SIGNED(1'b0), .PIPE_IN(1), .PIPE_OUT(2)) i_fxr_round_unit_d (
        .clk(clk), .rst(rst), .valid_i(vin), .din(stim), .valid_o(d_v),
        .trunc_o(d_t), .away_wrap_o(d_aw), .away_clip_o(d_ac), .even_wrap_o(d_ew), .even_clip_o(d_ec));

    // E: signed 4 bits, nothing dropped, combinational
    logic       e_v; logic [3:0] e_t, e_aw, e_ac, e_ew, e_ec;
    fxr_round_unit #(.IN_W(4), .DROP_W(0), .IS_SIGNED(1'b1), .PIPE_IN(0), .PIPE_OUT(0)) i_fxr_round_unit_e (
        .clk(clk), .rst(rst), .valid_i(vin), .din(stim[3:0]), .valid_o(e_v),
        .trunc_o(e_t), .away_wrap_o(e_aw), .away_clip_o(e_ac), .even_wrap_o(e_ew), .even_clip_o(e_ec));

    // Arithmetic model: mode 0 trunc, 1 away wrap, 2 away clip, 3 even wrap, 4 even clip
    function automatic int exp_val(int x, int w, int r, bit sgn, int mode, output string req);
        int q, rem, half, res, ow, maxv;
        bit clip, tie;
        if (r <= 0) begin
            req = "R8";
            return x;
        end
        q    = x >>> r;
        rem  = x - (q <<< r);
        half = 1 << (r - 1);
        tie  = (rem == half);
        res  = q;
        if (mode == 1 || mode == 2) begin
            if (rem > half || (tie && !(sgn && x < 0))) res = q + 1;
        end else if (mode == 3 || mode == 4) begin
            if (rem > half || (tie && (q % 2 != 0))) res = q + 1;
        end
        ow   = w - r;
        maxv = sgn ? (1 << (ow - 1)) - 1 : (1 << ow) - 1;
        clip = (mode == 2 || mode == 4);
        if (mode == 0) req = "R1";
        else if (res > maxv) req = clip ? "R7" : "R6";
        else if (tie) req = (mode >= 3) ? "R4" : (sgn ? "R2" : "R3");
        else req = "R5";
        if (clip && res > maxv) begin
            res = maxv;
        end else begin
            res = res & ((1 << ow) - 1);
            if (sgn && res > maxv) res = res - (1 << ow);
        end
        return res;
    endfunction

    task automatic chk(string nm, string req, int act, int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, nm, act, exp);
        end
    endtask

    task automatic check_inst(string nm, int w, int r, bit sgn, int lat, bit v,
                              int o0, int o1, int o2, int o3, int o4);
        int xr, x, e;
        string req;
        int act [5];
        act = '{o0, o1, o2, o3, o4};
        chk({nm, " valid"}, "R9", int'(v), int'(hist_v[lat]));
        if (hist_v[lat]) begin
            xr = hist_x[lat] & ((1 << w) - 1);
            x  = (sgn && xr >= (1 << (w - 1))) ? xr - (1 << w) : xr;
            for (int m = 0; m < 5; m++) begin
                e = exp_val(x, w, r, sgn, m, req);
                chk($sformatf("%s in=%0d mode=%0d", nm, x, m), req, act[m], e);
            end
        end
    endtask

    task automatic check_all();
        check_inst("A", 4, 1, 1'b1, 2, a_v, $signed(a_t), $signed(a_aw), $signed(a_ac), $signed(a_ew), $signed(a_ec));
        check_inst("B", 4, 1, 1'b0, 1, b_v, b_t, b_aw, b_ac, b_ew, b_ec);
        check_inst("C", 5, 2, 1'b1, 2, c_v, $signed(c_t), $signed(c_aw), $signed(c_ac), $signed(c_ew), $signed(c_ec));
        check_inst("D", 5, 2, 1'b0, 3, d_v, d_t, d_aw, d_ac, d_ew, d_ec);
        check_inst("E", 4, 0, 1'b1, 0, e_v, $signed(e_t), $signed(e_aw), $signed(e_ac), $signed(e_ew), $signed(e_ec));
    endtask

    task automatic clear_hist();
        for (int k = 0; k < 4; k++) begin
            hist_x[k] = 0;
            hist_v[k] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst  = 1'b1;
        vin  = 1'b0;
        stim = '0;
        @(negedge clk);
        rst = 1'b0;
        clear_hist();
        #2;
        // R10: everything registered reads zero after reset
        chk("A reset valid", "R10", int'(a_v), 0);
        chk("A reset trunc", "R10", int'(a_t), 0);
        chk("A reset even_clip", "R10", int'(a_ec), 0);
        chk("D reset valid", "R10", int'(d_v), 0);
        chk("D reset away_wrap", "R10", int'(d_aw), 0);
        chk("C reset trunc", "R10", int'(c_t), 0);
        check_all();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        clear_hist();
        do_reset();
        for (int pass = 0; pass < 2; pass++) begin
            for (int x = 0; x < 32; x++) begin
                @(negedge clk);
                stim = x[4:0];
                vin  = !((x % 7 == 3) && pass == 1);
                for (int k = 3; k > 0; k--) begin
                    hist_x[k] = hist_x[k-1];
                    hist_v[k] = hist_v[k-1];
                end
                hist_x[0] = x;
                hist_v[0] = vin;
                #2;
                check_all();
            end
            if (pass == 0) do_reset();
        end
        // drain so the deepest copy shows the last words
        for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            vin = 1'b0;
            for (int k = 3; k > 0; k--) begin
                hist_x[k] = hist_x[k-1];
                hist_v[k] = hist_v[k-1];
            end
            hist_x[0] = int'(stim);
            hist_v[0] = 1'b0;
            #2;
            check_all();
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule